// File: doc/BRIEF.md
# Square-Wave Tremolo Modulator

This block imposes an on/off amplitude envelope on a stream of signed audio samples. A strobe marks each new sample (one per left-right clock edge of the serial audio link, about 52 kHz). A two-phase sequencer splits every period of the control waveform into a loud phase and a quiet phase. During the loud phase samples pass untouched. During the quiet phase each sample is scaled down by an amount set by a depth code.

Three 8-bit codes control the envelope. The rate code sets the period length in samples. The duty code sets how that period is split between the two phases. The depth code sets how strongly the quiet phase is attenuated. A new code takes effect only when the next phase begins, so an envelope that is already running is never cut short. When the enable input is low, every sample is passed through unchanged.

Top module: `tremolo_mod`

## Requirements
- R1: After reset the output register holds 0, both phase counters are clear and the sequencer is in the loud phase. The first strobed sample after reset belongs to the loud phase unless that phase has zero length.
- R2: On a strobe with `en` low, the output becomes the strobed input sample, whatever the phase and depth.
- R3: The output is registered. It changes only on a clock edge where `smp_stb` is high, and it takes the new value one cycle after the strobe. Between strobes it holds.
- R4: The period in samples is T = floor(FS_HZ·255 / (18·rate + 510)). With FS_HZ = 600, rate 0 gives 300, rate 128 gives 54 and rate 255 gives 30.
- R5: Let n = floor(64·(255 − duty)/255). The quiet phase lasts floor(T·n/64) samples and the loud phase lasts the rest of T. The phases alternate, starting with loud. Separate loud and quiet counters run while their own phase is active, and at most one of them is nonzero at any time.
- R6: A phase of zero length is skipped. Duty 0 keeps every sample in the quiet phase, and duty 255 keeps every sample in the loud phase.
- R7: A quiet-phase sample x becomes x·(255 − depth)/255, rounded toward zero. Depth 0 leaves the sample unchanged and depth 255 gives 0.
- R8: Rate, duty and depth are sampled when a phase begins. A change in the middle of a phase alters neither its length nor its gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| en | input | 1 | Effect enable; low passes samples through |
| smp_in | input | DATA_W | Signed input sample |
| rate | input | CODE_W | Period code |
| depth | input | CODE_W | Attenuation code |
| duty | input | CODE_W | Loud/quiet split code |
| smp_out | output | DATA_W | Signed output sample, registered |

## Verification
The bench builds the block with FS_HZ = 600 and keeps the default widths. This shrinks the period to between 30 and 300 samples, so whole envelopes can be traced sample by sample at the slowest rate, the fastest rate and a middle rate. The small period also makes the zero-length phases at the duty extremes and the hand-over of mid-phase parameter changes at a boundary reachable in a few thousand cycles. The 24-bit width keeps the full-scale negative sample within reach for the attenuation rounding checks.

// File: rtl/tremolo_pkg.sv
package tremolo_pkg;

  typedef enum logic {PH_ON = 1'b0, PH_OFF = 1'b1} phase_e;

  // Period of the control square wave, in samples.
  function automatic int unsigned calc_period(int unsigned fs, int unsigned slope,
                                              int unsigned cmax, int unsigned rate);
    return (fs * cmax) / (slope * rate + 2 * cmax);
  endfunction

  // Samples spent in the quiet phase for a period t.
  function automatic int unsigned calc_off(int unsigned t, int unsigned frac_log2,
                                           int unsigned cmax, int unsigned duty);
    int unsigned num;
    num = ((32'd1 << frac_log2) * (cmax - duty)) / cmax;
    return (t * num) >> frac_log2;
  endfunction

endpackage

// File: rtl/trem_phase_counter.sv
module trem_phase_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= inc ? W'(1) : '0;
    else if (inc) cnt <= cnt + W'(1);
  end

  // R5
  cnt_within_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);

endmodule

// File: rtl/trem_sequencer.sv
module trem_sequencer
  import tremolo_pkg::*;
#(
  parameter int CODE_W         = 8,
  parameter int FS_HZ          = 52083,
  parameter int RATE_SLOPE     = 18,
  parameter int DUTY_FRAC_LOG2 = 6,
  parameter int CNT_W          = $clog2(FS_HZ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [CODE_W-1:0] rate,
  input  logic [CODE_W-1:0] duty,
  input  logic [CODE_W-1:0] depth,
  output phase_e            phase_now,
  output logic [CODE_W-1:0] depth_now
);

  localparam int unsigned CMAX = (32'd1 << CODE_W) - 32'd1;

  phase_e            st_q;
  logic [CNT_W-1:0]  len_q;
  logic [CODE_W-1:0] depth_q;

  logic [CNT_W-1:0]  cnt [2];
  logic [CNT_W-1:0]  cur_cnt, on_len, off_len, pref_len, pick_len;
  int unsigned       t_live, off_live;
  phase_e            pref, pick;
  logic              expired, boundary;

  // Lengths for the phase that would start now, from the live codes.
  always_comb begin
    t_live   = calc_period(FS_HZ, RATE_SLOPE, CMAX, 32'(rate));
    off_live = calc_off(t_live, DUTY_FRAC_LOG2, CMAX, 32'(duty));
    off_len  = CNT_W'(off_live);
    on_len   = CNT_W'(t_live - off_live);
  end

  always_comb begin
    cur_cnt  = (st_q == PH_ON) ? cnt[0] : cnt[1];
    expired  = (cur_cnt >= len_q);
    pref     = (st_q == PH_OFF || len_q == '0) ? PH_ON : PH_OFF;
    pref_len = (pref == PH_ON) ? on_len : off_len;
    if (!expired)              pick = st_q;
    else if (pref_len != '0)   pick = pref;
    else                       pick = (pref == PH_ON) ? PH_OFF : PH_ON;
    pick_len = (pick == PH_ON) ? on_len : off_len;
    boundary = smp_stb && expired;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_ON;
      len_q   <= '0;
      depth_q <= '0;
    end else if (boundary) begin
      st_q    <= pick;
      len_q   <= pick_len;
      depth_q <= depth;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    logic inc_i;
    assign inc_i = smp_stb && (pick == ((i == 0) ? PH_ON : PH_OFF));
    trem_phase_counter #(.W(CNT_W)) cnt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (inc_i),
      .clr  (boundary),
      .lim  (len_q),
      .cnt  (cnt[i])
    );
  end

  assign phase_now = pick;
  assign depth_now = boundary ? depth : depth_q;

  // R5
  one_counter_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt[0] != '0, cnt[1] != '0}));

  // R6
  skip_empty_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && on_len == '0) |-> (phase_now == PH_OFF));

  // R8
  len_held_mid_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !expired) |=> $stable(len_q));

endmodule

// File: rtl/trem_attenuator.sv
module trem_attenuator #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic        [CODE_W-1:0] depth,
  output logic signed [DATA_W-1:0] y
);

  localparam int PW = DATA_W + CODE_W + 2;
  localparam logic [CODE_W-1:0] FULL = '1;

  // Scale by (FULL - d)/FULL; signed division truncates toward zero.
  function automatic logic signed [DATA_W-1:0] scale(logic signed [DATA_W-1:0] s,
                                                     logic [CODE_W-1:0] d);
    logic signed [PW-1:0] xs, gs, prod, q;
    xs   = PW'(s);
    gs   = PW'($signed({1'b0, FULL - d}));
    prod = xs * gs;
    q    = prod / $signed(PW'({1'b0, FULL}));
    return q[DATA_W-1:0];
  endfunction

  assign y = scale(x, depth);

endmodule

// File: rtl/tremolo_mod.sv
module tremolo_mod
  import tremolo_pkg::*;
#(
  parameter int DATA_W         = 24,
  parameter int CODE_W         = 8,
  parameter int FS_HZ          = 52083,
  parameter int RATE_SLOPE     = 18,
  parameter int DUTY_FRAC_LOG2 = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] smp_in,
  input  logic        [CODE_W-1:0] rate,
  input  logic        [CODE_W-1:0] depth,
  input  logic        [CODE_W-1:0] duty,
  output logic signed [DATA_W-1:0] smp_out
);

  localparam int CNT_W = $clog2(FS_HZ + 1);

  phase_e                   phase_now;
  logic [CODE_W-1:0]        depth_now;
  logic signed [DATA_W-1:0] att;

  trem_sequencer #(
    .CODE_W        (CODE_W),
    .FS_HZ         (FS_HZ),
    .RATE_SLOPE    (RATE_SLOPE),
    .DUTY_FRAC_LOG2(DUTY_FRAC_LOG2),
    .CNT_W         (CNT_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .rate     (rate),
    .duty     (duty),
    .depth    (depth),
    .phase_now(phase_now),
    .depth_now(depth_now)
  );

  trem_attenuator #(.DATA_W(DATA_W), .CODE_W(CODE_W)) att_i (
    .x    (smp_in),
    .depth(depth_now),
    .y    (att)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       smp_out <= '0;
    else if (smp_stb) smp_out <= (en && phase_now == PH_OFF) ? att : smp_in;
  end

  // R2
  bypass_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !en) |=> (smp_out == $past(smp_in)));

  // R3
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(smp_out));

  // R7
  full_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && en && phase_now == PH_OFF && depth_now == '1) |=> (smp_out == '0));

endmodule

// File: tb/tremolo_mod_tb.sv
module tremolo_mod_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FS         = 600;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_stb = 1'b0;
  logic               en = 1'b1;
  logic signed [23:0] smp_in = '0;
  logic        [7:0]  rate = '0, depth = '0, duty = '0;
  logic signed [23:0] smp_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tremolo_mod #(.FS_HZ(FS)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .en(en), .smp_in(smp_in),
    .rate(rate), .depth(depth), .duty(duty), .smp_out(smp_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    smp_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Present one sample and return the output one cycle later.
  task automatic send(input int x, output int y);
    @(negedge clk);
    smp_in  = 24'(x);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    y = int'(smp_out);
  endtask

  // Phase lengths from R4 and R5.
  task automatic mdl_len(input int r, input int d, output int on_n, output int off_n);
    int t, n;
    t     = (FS * 255) / (18 * r + 510);
    n     = (64 * (255 - d)) / 255;
    off_n = (t * n) / 64;
    on_n  = t - off_n;
  endtask

  function automatic bit mdl_quiet(int k, int on_n, int off_n);
    if (on_n == 0)  return 1'b1;
    if (off_n == 0) return 1'b0;
    return (k % (on_n + off_n)) >= on_n;
  endfunction

  // R7 gain, computed on the magnitude.
  function automatic int mdl_att(int x, int d);
    longint p, m;
    p = longint'(x) * longint'(255 - d);
    m = (p < 0) ? -p : p;
    m = m / 255;
    return int'((p < 0) ? -m : m);
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 output after reset", int'(smp_out), 0);
  endtask

  task automatic t_hold();
    int y;
    do_reset();
    rate = 8'd255; duty = 8'd127; depth = 8'd255; en = 1'b1;
    send(500, y);
    chk("R3 output after strobe", y, 500);
    smp_in = 24'sd777;
    repeat (5) @(negedge clk);
    chk("R3 output held without strobe", int'(smp_out), 500);
  endtask

  task automatic t_bypass();
    int y;
    int vals[5] = '{123, -456, 8388607, -8388608, 1};
    do_reset();
    rate = 8'd255; duty = 8'd0; depth = 8'd255; en = 1'b0;
    foreach (vals[i]) begin
      send(vals[i], y);
      chk("R2 disabled passthrough", y, vals[i]);
    end
    en = 1'b1;
    send(999, y);
    chk("R6 duty 0 mutes once enabled", y, 0);
  endtask

  task automatic t_pattern(input string tag, input int r, input int d, input int n);
    int on_n, off_n, y, e;
    do_reset();
    rate = 8'(r); duty = 8'(d); depth = 8'd255; en = 1'b1;
    mdl_len(r, d, on_n, off_n);
    for (int k = 0; k < n; k++) begin
      send(1000, y);
      e = mdl_quiet(k, on_n, off_n) ? 0 : 1000;
      chk(tag, y, e);
    end
  endtask

  task automatic t_depth(input int d, input int x);
    int y;
    do_reset();
    rate = 8'd255; duty = 8'd127; depth = 8'(d); en = 1'b1;
    // Loud phase lasts 15 samples at FS=600, rate 255, duty 127.
    for (int k = 0; k < 15; k++) send(0, y);
    send(x, y);
    chk("R7 quiet-phase gain", y, mdl_att(x, d));
  endtask

  task automatic t_latch_rate();
    int y;
    do_reset();
    rate = 8'd255; duty = 8'd127; depth = 8'd255; en = 1'b1;
    for (int k = 0; k < 41; k++) begin
      if (k == 5) rate = 8'd0;
      send(1000, y);
      // Loud phase keeps 15 samples; the quiet phase then takes 150.
      chk("R8 rate change waits for boundary", y, (k < 15) ? 1000 : 0);
    end
  endtask

  task automatic t_latch_depth();
    int y, e;
    do_reset();
    rate = 8'd255; duty = 8'd127; depth = 8'd255; en = 1'b1;
    for (int k = 0; k < 46; k++) begin
      if (k == 16) depth = 8'd0;
      send(1000, y);
      if (k < 15)      e = 1000;
      else if (k < 30) e = 0;
      else             e = 1000;
      chk("R8 depth change waits for boundary", y, e);
    end
  endtask

  initial begin
    int on_n, off_n;
    t_reset();
    // R4 sanity on the period model
    mdl_len(0, 127, on_n, off_n);
    chk("R4 period at rate 0", on_n + off_n, 300);
    mdl_len(255, 200, on_n, off_n);
    chk("R5 quiet length at duty 200", off_n, 6);
    t_hold();
    t_bypass();
    t_pattern("R4 slowest rate envelope", 0, 127, 620);
    t_pattern("R4 mid rate envelope", 128, 64, 120);
    t_pattern("R5 fast rate even split", 255, 127, 70);
    t_pattern("R5 fast rate duty 200", 255, 200, 70);
    t_pattern("R6 duty 0 all quiet", 255, 0, 40);
    t_pattern("R6 duty 255 all loud", 255, 255, 40);
    t_depth(0, 12345);
    t_depth(127, -1000);
    t_depth(255, 8388607);
    t_depth(1, -8388608);
    t_depth(200, 777);
    t_latch_rate();
    t_latch_depth();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule